// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Cycle Decoder

This block is the control front end of a common-I/O synchronous static RAM whose read and write data phases share one set of bidirectional pins, with no idle cycle needed between a read and a write. On every enabled rising clock edge it samples the chip selects, the load/continue control, the write enable and the per-byte write selects. From these it classifies the cycle, keeps an internal two-bit burst counter, and registers the cycle's operation, word address and byte selects into a single data-phase stage. The stage decides what happens on the shared pins during the following cycle.

Reads present the addressed word on the pins in the cycle after their address edge, gated by an asynchronous output enable. Writes take their data from the pins in the cycle after their address edge, and store it at the next enabled edge, lane by lane. The write data phase therefore lines up with the read data phase, and accesses of either kind can follow each other on consecutive edges. Holding the clock enable inactive inserts wait states in which nothing advances. A small lane-organised storage array stands in for the memory core so that lane gating and burst ordering can be observed at the pins.

Top module: `sram_cycle_decoder`

## Requirements
- R1: Synchronous active-low reset leaves the block deselected (`cyc_kind` = 0), the pins undriven whatever `oe_n` is, no lane strobe active, and every storage word zero.
- R2: On an enabled edge with `burst_cont` = 0 and every bit of `cs_n` low, `we_n` = 1 starts a read (`cyc_kind` = 2), and `we_n` = 0 with at least one `bw_n` bit low starts a write (`cyc_kind` = 6). `addr` is loaded as the burst start.
- R3: On an enabled edge with `burst_cont` = 0 and any `cs_n` bit high, the cycle is a deselect (`cyc_kind` = 0) whatever `we_n` is, and the pins stay undriven.
- R4: On an enabled edge with `burst_cont` = 1, `cs_n` and `we_n` are ignored and the cycle continues the previous operation: deselect (0 or 1) gives 1, read (2 or 3) gives 3, dummy (4 or 5) gives 5, write (6 or 7) gives 7.
- R5: Each continue cycle steps a two-bit burst offset that wraps after four words. With `burst_lin` = 1 the low two address bits are start + offset (mod 4); with `burst_lin` = 0 they are start XOR offset. The upper address bits stay those of the start.
- R6: In a write data phase, `lane_wr` bit i is high exactly when `bw_n` bit i was low at the address edge, and only those 9-bit lanes (lane i = `dq` bits 9i+8..9i) of the addressed word are replaced at the next enabled edge.
- R7: During the data phase of any write or dummy cycle the block never drives `dq`, even with `oe_n` low.
- R8: During a read data phase (`cyc_kind` 2 or 3), `dq` carries the addressed word and `dq_drive` is 1 exactly while `oe_n` is low; `oe_n` acts without a clock edge.
- R9: An edge with `cke_n` = 1 is a wait state: the cycle kind, stage address, byte selects and burst offset hold, no write is stored, and a pending write's data is taken at the next enabled edge instead.
- R10: A write start with every `bw_n` bit high is a dummy (`cyc_kind` = 4); its continues are dummies (5); neither stores data nor drives the pins.
- R11: A read issued on the edge directly after a write's address edge to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, low to advance, high inserts a wait state |
| cs_n | input | NCS (3) | Chip selects, the device is selected only when all are low |
| burst_cont | input | 1 | 0 loads a new access, 1 continues the current burst |
| we_n | input | 1 | Write enable for a new access, low for write |
| bw_n | input | LANES (4) | Active-low byte-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable for read data |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW (4) | Word address for a new access |
| dq | inout | LANES*LANE_W (36) | Shared data pins |
| cyc_kind | output | 3 | Kind of the cycle classified at the last enabled edge |
| dq_drive | output | 1 | High while the block drives `dq` |
| lane_wr | output | LANES (4) | Lanes that the pending write phase will store |

## Verification
The hardest situation to reach is a wait state that falls inside a write data phase while a burst is in flight. In that case the data on the pins changes across the stalled edge, and only the value present at the next enabled edge may land, in the lanes chosen one stage earlier. The directed part of the stimulus builds this case on purpose: it stalls a linear write burst in the middle and changes the pin data during the stall. It also stalls a read burst while the selects and address lines move. A long pseudo-random phase then mixes stalls, continue cycles, partial lane selects, dummies and both burst orders, and a behavioural queue-free model in the bench tracks the whole pipeline on every clock.

// File: rtl/sram_dec_pkg.sv
// Shared types and helpers for the SRAM cycle decoder.
// Assumes the cycle encoding below is visible at the top-level port.
package sram_dec_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL      = 3'd0,
        CYC_DESEL_CONT = 3'd1,
        CYC_RD         = 3'd2,
        CYC_RD_CONT    = 3'd3,
        CYC_DUMMY      = 3'd4,
        CYC_DUMMY_CONT = 3'd5,
        CYC_WR         = 3'd6,
        CYC_WR_CONT    = 3'd7
    } cyc_t;

    // True for a read start or read continue.
    function automatic logic is_read(input cyc_t k);
        return (k == CYC_RD) || (k == CYC_RD_CONT);
    endfunction

    // True for a write start or write continue (dummies excluded).
    function automatic logic is_write(input cyc_t k);
        return (k == CYC_WR) || (k == CYC_WR_CONT);
    endfunction

    // Continue variant of a given operation.
    function automatic cyc_t cont_of(input cyc_t k);
        cyc_t r;
        case (k)
            CYC_RD, CYC_RD_CONT:       r = CYC_RD_CONT;
            CYC_DUMMY, CYC_DUMMY_CONT: r = CYC_DUMMY_CONT;
            CYC_WR, CYC_WR_CONT:       r = CYC_WR_CONT;
            default:                   r = CYC_DESEL_CONT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_cyc_classify.sv
// Combinational cycle classifier.
// Decides the kind of the cycle presented at the coming edge from the control
// pins and the kind of the previous cycle. Assumes the caller registers the
// result only on enabled edges.
module sram_cyc_classify
    import sram_dec_pkg::*;
#(
    parameter int NCS   = 3,
    parameter int LANES = 4
) (
    input  logic [NCS-1:0]   cs_n,
    input  logic             burst_cont,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  cyc_t             last_kind,
    output cyc_t             next_kind,
    output logic             load
);

    logic selected;
    logic no_lanes;

    // Selection and lane summary.
    always_comb begin
        selected = (cs_n == '0);
        no_lanes = &bw_n;
        load     = !burst_cont;
    end

    // Kind decision: continue reuses the last operation, load decodes pins.
    always_comb begin
        if (burst_cont) begin
            next_kind = cont_of(last_kind);
        end else if (!selected) begin
            next_kind = CYC_DESEL;
        end else if (!we_n) begin
            next_kind = no_lanes ? CYC_DUMMY : CYC_WR;
        end else begin
            next_kind = CYC_RD;
        end
    end

endmodule

// File: rtl/sram_burst_addr.sv
// Burst address generator.
// Holds the burst start and a two-bit offset; produces the word address of the
// cycle at the coming edge in linear or interleaved order. Assumes AW >= 2.
module sram_burst_addr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr
);

    localparam int OW = 2;

    logic [AW-1:0] base_q;
    logic [OW-1:0] offs_q;
    logic [OW-1:0] offs_nx;
    logic [OW-1:0] low_nx;

    // Next offset and low address bits for a continue cycle.
    always_comb begin
        offs_nx = offs_q + 2'd1;
        low_nx  = linear ? (base_q[OW-1:0] + offs_nx) : (base_q[OW-1:0] ^ offs_nx);
        if (load) begin
            cur_addr = addr_in;
        end else begin
            cur_addr = {base_q[AW-1:OW], low_nx};
        end
    end

    // Start address and offset registers, frozen on wait states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            offs_q <= '0;
        end else if (step) begin
            if (load) begin
                base_q <= addr_in;
                offs_q <= '0;
            end else begin
                offs_q <= offs_nx;
            end
        end
    end

    AST_OFFS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        step && load |=> offs_q == '0); // R5
    AST_OFFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> offs_q == $past(offs_q) + 2'd1); // R5
    AST_OFFS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(offs_q) && $stable(base_q)); // R9

endmodule

// File: rtl/sram_lane_array.sv
// Lane-organised storage model.
// DEPTH words of LANES lanes, each LANE_W bits; synchronous per-lane write,
// combinational read. Cleared by reset so contents are defined from the start.
module sram_lane_array #(
    parameter int AW     = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Store this lane when the write is enabled for it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    lane_mem[w] <= '0;
                end
            end else if (wr_en && lane_en[l]) begin
                lane_mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        // Present this lane of the read word.
        assign rd_data[l*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/sram_cycle_decoder.sv
// Pipelined synchronous SRAM cycle decoder, top level.
// Classifies each enabled cycle, registers one data-phase stage, drives the
// shared pins for reads under the asynchronous output enable, and stores
// write data one stage after its address. Assumes cke_n is synchronous.
module sram_cycle_decoder
    import sram_dec_pkg::*;
#(
    parameter int NCS    = 3,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int AW     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic [NCS-1:0]          cs_n,
    input  logic                    burst_cont,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    burst_lin,
    input  logic [AW-1:0]           addr,
    inout  wire  [LANES*LANE_W-1:0] dq,
    output logic [2:0]              cyc_kind,
    output logic                    dq_drive,
    output logic [LANES-1:0]        lane_wr
);

    localparam int DW = LANES * LANE_W;

    logic             step;
    logic             load;
    cyc_t             next_kind;
    logic [AW-1:0]    cur_addr;
    cyc_t             st_kind;
    logic [AW-1:0]    st_addr;
    logic [LANES-1:0] st_bw;
    logic             st_wr;
    logic             commit;
    logic [DW-1:0]    rd_word;

    assign step = !cke_n;

    sram_cyc_classify #(.NCS(NCS), .LANES(LANES)) u_classify (
        .cs_n       (cs_n),
        .burst_cont (burst_cont),
        .we_n       (we_n),
        .bw_n       (bw_n),
        .last_kind  (st_kind),
        .next_kind  (next_kind),
        .load       (load)
    );

    sram_burst_addr #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (load),
        .linear   (burst_lin),
        .addr_in  (addr),
        .cur_addr (cur_addr)
    );

    // Data-phase stage: kind, address and lane selects, frozen on wait states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_kind <= CYC_DESEL;
            st_addr <= '0;
            st_bw   <= '1;
        end else if (step) begin
            st_kind <= next_kind;
            st_addr <= cur_addr;
            st_bw   <= bw_n;
        end
    end

    // Write phase decode and commit on the next enabled edge.
    always_comb begin
        st_wr   = is_write(st_kind);
        commit  = step && st_wr;
        lane_wr = st_wr ? ~st_bw : '0;
    end

    sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_addr (st_addr),
        .lane_en (~st_bw),
        .wr_data (dq),
        .rd_addr (st_addr),
        .rd_data (rd_word)
    );

    // Pin drive: read phase with output enable active only.
    always_comb begin
        dq_drive = is_read(st_kind) && !oe_n;
        cyc_kind = st_kind;
    end

    assign dq = dq_drive ? rd_word : {DW{1'bz}};

    AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(st_kind) && $stable(st_addr) && $stable(st_bw)); // R9
    AST_CONT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        step && burst_cont && is_read(st_kind) |=> st_kind == CYC_RD_CONT); // R4
    AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        step && !burst_cont && (cs_n != '0) |=> st_kind == CYC_DESEL && !dq_drive); // R3
    AST_DUMMY_START: assert property (@(posedge clk) disable iff (!rst_n)
        step && !burst_cont && (cs_n == '0) && !we_n && (&bw_n) |=> st_kind == CYC_DUMMY && lane_wr == '0); // R10
    AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        step && !burst_cont && (cs_n == '0) && !we_n && !(&bw_n) |=> lane_wr == ~$past(bw_n)); // R6

endmodule

// File: tb/sram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module sram_cycle_decoder_bench;

    localparam int NCS = 3;
    localparam int LN  = 4;
    localparam int LW  = 9;
    localparam int AW  = 4;
    localparam int DW  = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic [NCS-1:0] cs_n = '1;
    logic          burst_cont = 1'b0;
    logic          we_n = 1'b1;
    logic [LN-1:0] bw_n = '1;
    logic          oe_n = 1'b0;
    logic          burst_lin = 1'b1;
    logic [AW-1:0] addr = '0;
    wire  [DW-1:0] dq;
    logic [2:0]    cyc_kind;
    logic          dq_drive;
    logic [LN-1:0] lane_wr;

    logic          tb_en = 1'b0;
    logic [DW-1:0] tb_val = '0;
    assign dq = tb_en ? tb_val : {DW{1'bz}};

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // behavioural model state
    int            m_kind;
    logic [AW-1:0] m_addr;
    logic [LN-1:0] m_bw;
    logic [AW-1:0] m_base;
    logic [1:0]    m_offs;
    logic [DW-1:0] m_mem [16];
    logic          m_waited;

    always #2 clk = ~clk;

    sram_cycle_decoder u_sram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n),
        .burst_cont(burst_cont), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
        .burst_lin(burst_lin), .addr(addr), .dq(dq), .cyc_kind(cyc_kind),
        .dq_drive(dq_drive), .lane_wr(lane_wr)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string kind_tag(input int k);
        if (k == 0) return "R3";
        if (k == 2 || k == 6) return "R2";
        if (k == 4 || k == 5) return "R10";
        return "R4";
    endfunction

    function automatic int cont_kind(input int k);
        if (k <= 1) return 1;
        if (k <= 3) return 3;
        if (k <= 5) return 5;
        return 7;
    endfunction

    // Compare outputs against the model, then advance one edge.
    task automatic tick(input logic [DW-1:0] wd);
        logic wph;
        logic rph;
        wph = (m_kind == 6 || m_kind == 7);
        rph = (m_kind == 2 || m_kind == 3);
        tb_en  = wph;
        tb_val = wd;
        #1;
        chk(cyc_kind == 3'(m_kind), m_waited ? "R9" : kind_tag(m_kind), "cyc_kind",
            DW'(cyc_kind), DW'(m_kind));
        chk(dq_drive == (rph && !oe_n), rph ? "R8" : "R7", "dq_drive",
            DW'(dq_drive), DW'(rph && !oe_n));
        chk(lane_wr == (wph ? ~m_bw : '0), "R6", "lane_wr",
            DW'(lane_wr), DW'(wph ? ~m_bw : 4'b0));
        if (rph && !oe_n)
            chk(dq === m_mem[m_addr], cur_tag, "read data", dq, m_mem[m_addr]);
        @(posedge clk);
        m_waited = cke_n;
        if (!cke_n) begin
            if (wph) begin
                for (int l = 0; l < LN; l++)
                    if (!m_bw[l]) m_mem[m_addr][l*LW +: LW] = tb_val[l*LW +: LW];
            end
            if (burst_cont) begin
                m_kind = cont_kind(m_kind);
                m_offs = m_offs + 2'd1;
                m_addr = {m_base[AW-1:2],
                          burst_lin ? m_base[1:0] + m_offs : m_base[1:0] ^ m_offs};
            end else begin
                if (cs_n != '0) m_kind = 0;
                else if (!we_n) m_kind = (&bw_n) ? 4 : 6;
                else m_kind = 2;
                m_base = addr;
                m_offs = 2'd0;
                m_addr = addr;
            end
            m_bw = bw_n;
        end
        @(negedge clk);
    endtask

    task automatic cyc(input logic [2:0] cs, input logic cont, input logic we,
                       input logic [3:0] bw, input logic [3:0] a, input logic oe,
                       input logic ck, input logic [DW-1:0] wd);
        cs_n = cs; burst_cont = cont; we_n = we; bw_n = bw;
        addr = a; oe_n = oe; cke_n = ck;
        tick(wd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        m_kind = 0; m_addr = '0; m_bw = '1; m_base = '0; m_offs = '0; m_waited = 0;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        // R1: reset with oe_n active
        oe_n = 1'b0; cs_n = '0; we_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cyc_kind == 3'd0, "R1", "reset kind", DW'(cyc_kind), '0);
        chk(dq_drive == 1'b0, "R1", "reset drive", DW'(dq_drive), '0);
        chk(lane_wr == '0, "R1", "reset lanes", DW'(lane_wr), '0);
        rst_n = 1'b1;
        // R1: storage cleared, read word 5
        cyc(3'b000, 0, 1, 4'hF, 4'd5, 0, 0, '0);
        cyc(3'b001, 0, 1, 4'hF, 4'd0, 0, 0, '0);
        // R5: linear write burst from 3 with a mid-burst stall (R9)
        cur_tag = "R5"; burst_lin = 1'b1;
        cyc(3'b000, 0, 0, 4'h0, 4'd3, 0, 0, '0);
        cyc(3'b111, 1, 1, 4'h0, 4'd9, 0, 0, 36'h0A1A2A3A4);
        cyc(3'b000, 0, 0, 4'h0, 4'd1, 0, 1, 36'h0DEADBEEF);
        cyc(3'b000, 1, 1, 4'h0, 4'd0, 0, 0, 36'h0B1B2B3B4);
        cyc(3'b000, 1, 1, 4'h0, 4'd0, 0, 0, 36'h0C1C2C3C4);
        cyc(3'b000, 0, 1, 4'hF, 4'd3, 0, 0, 36'h0D1D2D3D4);
        // R11-adjacent linear read burst with a stall
        cyc(3'b000, 1, 0, 4'hF, 4'd0, 0, 0, '0);
        cyc(3'b101, 0, 0, 4'h0, 4'd7, 0, 1, '0);
        cyc(3'b000, 1, 0, 4'hF, 4'd0, 0, 0, '0);
        cyc(3'b000, 1, 0, 4'hF, 4'd0, 0, 0, '0);
        // R5: interleaved write then read from 6
        burst_lin = 1'b0;
        cyc(3'b000, 0, 0, 4'h0, 4'd6, 0, 0, '0);
        cyc(3'b000, 1, 0, 4'h0, 4'd0, 0, 0, 36'h111111111);
        cyc(3'b000, 1, 0, 4'h0, 4'd0, 0, 0, 36'h222222222);
        cyc(3'b000, 1, 0, 4'h0, 4'd0, 0, 0, 36'h333333333);
        cyc(3'b000, 0, 1, 4'hF, 4'd6, 0, 0, 36'h044444444);
        for (int i = 0; i < 3; i++) cyc(3'b000, 1, 1, 4'hF, 4'd0, 0, 0, '0);
        // R6: partial lane write then read back
        cur_tag = "R6"; burst_lin = 1'b1;
        cyc(3'b000, 0, 0, 4'b1010, 4'd3, 0, 0, '0);
        cyc(3'b000, 0, 1, 4'hF, 4'd3, 0, 0, 36'hFFFFFFFFF);
        // R10: dummy write and continue, then read unchanged
        cur_tag = "R10";
        cyc(3'b000, 0, 0, 4'hF, 4'd3, 0, 0, '0);
        cyc(3'b000, 1, 0, 4'hF, 4'd3, 0, 0, '0);
        cyc(3'b000, 0, 1, 4'hF, 4'd3, 0, 0, 36'h123456789);
        // R3/R4: partial deselect, continue ignoring selects and we_n
        cur_tag = "R4";
        cyc(3'b010, 0, 0, 4'h0, 4'd2, 0, 0, '0);
        cyc(3'b000, 1, 0, 4'h0, 4'd2, 0, 0, '0);
        cyc(3'b000, 0, 1, 4'hF, 4'd4, 0, 0, '0);
        cyc(3'b111, 1, 0, 4'h0, 4'd4, 0, 0, '0);
        // R8: output enable toggled in read phase
        cur_tag = "R8";
        cyc(3'b000, 0, 1, 4'hF, 4'd4, 1, 0, '0);
        cyc(3'b000, 1, 1, 4'hF, 4'd4, 0, 0, '0);
        // R11: back-to-back write then read same word
        cur_tag = "R11";
        cyc(3'b000, 0, 0, 4'h0, 4'd9, 0, 0, '0);
        cyc(3'b000, 0, 1, 4'hF, 4'd9, 0, 0, 36'h9A9A9A9A9);
        cyc(3'b000, 0, 0, 4'b0110, 4'd9, 0, 0, '0);
        cyc(3'b000, 0, 1, 4'hF, 4'd9, 0, 0, 36'h555555555);
        cyc(3'b110, 0, 1, 4'hF, 4'd0, 0, 0, '0);
        // mixed pseudo-random traffic
        cur_tag = "R6";
        lf = 32'hACE1_2345;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            burst_lin = (i % 200) < 100;
            cyc((lf[3:2] == 2'b00) ? 3'(lf[6:4] | 3'b001) : 3'b000,
                lf[7], lf[8], lf[12:9], lf[16:13], lf[18:17] == 2'b00,
                lf[21:19] == 3'b000, {lf[3:0], lf}); 
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule